// File: doc/BRIEF.md
# Memory-Mapped Event Timer

The block is a precision event timer reached through a 32-bit register port. A main counter advances by one tick on every clock while its global enable is set. The clock is taken to be 100 MHz, so one tick is 10 ns. Software can stop the counter in place, preload it with a new value, and start it again from that value. Each of a small, parameterised set of comparator timers fires a one-cycle interrupt pulse in a cycle where the running counter equals its comparator. The firing is also latched in a status register, which is cleared by writing ones.

A legacy-replacement bit in the configuration register takes over two older interrupt lines: the interval-timer line and the real-time-clock line. When the bit is clear, those lines pass straight through the block. When it is set, the incoming sources are blocked at once, and the pulses of timer 0 and timer 1 drive the two lines in their place. Only full 32-bit accesses, with all four byte enables set, are decoded.

Top module: `et_event_timer`

## Requirements
- R1: A read at offset 0x00 returns the fixed identification word 0x8086A201, and a write to 0x00 leaves that value unchanged.
- R2: A read at offset 0x04 returns the tick period in femtoseconds, 0x00989680 (10,000,000 fs, or 10 ns).
- R3: The configuration register at 0x10 holds the counter enable in bit 0 and the legacy-route enable in bit 1. A write always applies these two bits, even when reserved bits are set. A read returns the two bits with all upper bits zero.
- R4: Offset 0x14 and every unmapped offset read as zero.
- R5: Offset 0xF0 reads the main counter. The counter rises by exactly one per clock while enabled, and it holds its value while the enable is clear.
- R6: A write to 0xF0 loads the counter. After the enable is next set, counting continues from the loaded value.
- R7: Comparator i sits at offset 0x40 + 8*i, is readable and writable, and resets to 0xFFFFFFFF.
- R8: While the enable is set, irq_out[i] pulses for exactly one cycle in each cycle where the counter equals comparator i. No pulse occurs while the enable is clear. The 32-bit counter wraps from 0xFFFFFFFF to 0.
- R9: Status register bit i at 0x20 is set by a match on timer i. Writing 1 to bit i clears it, and writing 0 leaves it unchanged. If a match and a clear fall in the same cycle, the match wins.
- R10: With legacy route clear, pit_irq_out follows pit_irq_in and rtc_irq_out follows rtc_irq_in. With it set, both inputs are blocked in the same cycle. pit_irq_out then carries the timer 0 pulse and rtc_irq_out the timer 1 pulse, while irq_out[0] and irq_out[1] stay low.
- R11: An access with be other than 4'hF is ignored: a write changes no register, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| be | input | 4 | Byte enables; only 4'hF is decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq_out | output | NUM_TIMERS | One-cycle match pulse per timer |
| pit_irq_in | input | 1 | Interrupt from the older interval timer |
| rtc_irq_in | input | 1 | Interrupt from the real-time clock |
| pit_irq_out | output | 1 | Interval-timer interrupt line after legacy routing |
| rtc_irq_out | output | 1 | RTC interrupt line after legacy routing |

## Verification
The assertions assume two things about the inputs. First, a write to the counter or to a comparator counts as a deliberate event, so the one-cycle pulse property exempts cycles that carry such a write. Second, no match event is expected to repeat unless a write has occurred or the counter has completed a full 2^32 wrap. The stimulus stays within these limits: every counter window it exercises spans at most a few dozen ticks. It changes comparators and preloads only while the enable is clear, or well away from the comparator value being tested. The wrap case places the counter three ticks below the top, so it never returns to a previously matched value.

// File: rtl/et_pkg.sv
`timescale 1ns/1ps
package et_pkg;
  localparam int ET_DW = 32;
  localparam int ET_AW = 8;
  localparam logic [ET_DW-1:0] ET_ID_WORD   = 32'h8086_A201;
  localparam logic [ET_DW-1:0] ET_PERIOD_FS = 32'd10_000_000;
  localparam logic [ET_DW-1:0] ET_CMP_RESET = '1;

  localparam logic [ET_AW-1:0] OFS_ID     = 8'h00;
  localparam logic [ET_AW-1:0] OFS_PERIOD = 8'h04;
  localparam logic [ET_AW-1:0] OFS_CFG    = 8'h10;
  localparam logic [ET_AW-1:0] OFS_STAT   = 8'h20;
  localparam logic [ET_AW-1:0] OFS_CMP0   = 8'h40;
  localparam logic [ET_AW-1:0] OFS_CNT    = 8'hF0;
  localparam int CMP_STRIDE = 8;

  typedef struct packed {
    logic leg;
    logic en;
  } cfg_t;

  function automatic logic [ET_AW-1:0] cmp_addr(input int idx);
    return ET_AW'(int'(OFS_CMP0) + idx * CMP_STRIDE);
  endfunction

  function automatic logic [ET_DW-1:0] cnt_next(input logic [ET_DW-1:0] cur,
                                                input logic run, input logic load,
                                                input logic [ET_DW-1:0] val);
    if (load) return val;
    if (run)  return cur + ET_DW'(1);
    return cur;
  endfunction

  function automatic logic sticky_w1c(input logic old, input logic set, input logic clr);
    return set | (old & ~clr);
  endfunction
endpackage

// File: rtl/et_main_counter.sv
`timescale 1ns/1ps
module et_main_counter #(
  parameter int W = et_pkg::ET_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= et_pkg::cnt_next(count, run, load, load_val);
  end
endmodule

// File: rtl/et_cmp_unit.sv
`timescale 1ns/1ps
module et_cmp_unit #(
  parameter int W = et_pkg::ET_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] count,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         clr,
  output logic [W-1:0] cmp_val,
  output logic         match,
  output logic         status
);
  assign match = run && (count == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= et_pkg::ET_CMP_RESET;
      status  <= 1'b0;
    end else begin
      if (wr) cmp_val <= wval;
      status <= et_pkg::sticky_w1c(status, match, clr);
    end
  end
endmodule

// File: rtl/et_irq_route.sv
`timescale 1ns/1ps
module et_irq_route #(
  parameter int N = 3
) (
  input  logic         legacy,
  input  logic [N-1:0] match,
  input  logic         pit_in,
  input  logic         rtc_in,
  output logic [N-1:0] irq_out,
  output logic         pit_out,
  output logic         rtc_out
);
  for (genvar g = 0; g < N; g++) begin : g_line
    if (g < 2) begin : g_shared
      assign irq_out[g] = match[g] & ~legacy;
    end else begin : g_plain
      assign irq_out[g] = match[g];
    end
  end

  assign pit_out = legacy ? match[0] : pit_in;
  assign rtc_out = legacy ? match[1] : rtc_in;
endmodule

// File: rtl/et_event_timer.sv
`timescale 1ns/1ps
module et_event_timer #(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [3:0]            be,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NUM_TIMERS-1:0] irq_out,
  input  logic                  pit_irq_in,
  input  logic                  rtc_irq_in,
  output logic                  pit_irq_out,
  output logic                  rtc_irq_out
);
  import et_pkg::*;
  localparam int DW = ET_DW;

  logic           acc_ok, wr_ok, rd_ok;
  logic           cfg_wr, cnt_load, stat_wr;
  cfg_t           cfg;
  logic [DW-1:0]  count;
  logic [NUM_TIMERS-1:0] cmp_wr, match_evt, status;
  logic [DW-1:0]  cmp_val [NUM_TIMERS];

  assign acc_ok   = (be == 4'hF);
  assign wr_ok    = wr_en && acc_ok;
  assign rd_ok    = rd_en && acc_ok;
  assign cfg_wr   = wr_ok && (addr == OFS_CFG);
  assign cnt_load = wr_ok && (addr == OFS_CNT);
  assign stat_wr  = wr_ok && (addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (cfg_wr) cfg <= '{leg: wdata[1], en: wdata[0]};
  end

  et_main_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg.en), .load(cnt_load),
    .load_val(wdata), .count(count)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    assign cmp_wr[g] = wr_ok && (addr == cmp_addr(g));
    et_cmp_unit #(.W(DW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .run(cfg.en), .count(count),
      .wr(cmp_wr[g]), .wval(wdata), .clr(stat_wr && wdata[g]),
      .cmp_val(cmp_val[g]), .match(match_evt[g]), .status(status[g])
    );
  end

  et_irq_route #(.N(NUM_TIMERS)) u_route (
    .legacy(cfg.leg), .match(match_evt), .pit_in(pit_irq_in), .rtc_in(rtc_irq_in),
    .irq_out(irq_out), .pit_out(pit_irq_out), .rtc_out(rtc_irq_out)
  );

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (addr)
        OFS_ID:     rdata = ET_ID_WORD;
        OFS_PERIOD: rdata = ET_PERIOD_FS;
        OFS_CFG:    rdata = {30'd0, cfg.leg, cfg.en};
        OFS_STAT:   rdata = DW'(status);
        OFS_CNT:    rdata = count;
        default: begin
          for (int i = 0; i < NUM_TIMERS; i++)
            if (addr == cmp_addr(i)) rdata = cmp_val[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/et_event_timer_chk.sv
`timescale 1ns/1ps
module et_event_timer_chk #(
  parameter int NUM_TIMERS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wr,
  input logic                  cnt_load,
  input logic [NUM_TIMERS-1:0] cmp_wr,
  input logic [31:0]           wdata,
  input logic                  cfg_en,
  input logic                  cfg_leg,
  input logic [31:0]           count,
  input logic [NUM_TIMERS-1:0] match_evt,
  input logic [NUM_TIMERS-1:0] status,
  input logic [NUM_TIMERS-1:0] irq_out,
  input logic                  pit_irq_out
);
  assert_cfg_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_en == $past(wdata[0]) && cfg_leg == $past(wdata[1])));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cnt_load) |=> count == 32'($past(count) + 32'd1));

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cnt_load) |=> $stable(count));

  assert_cnt_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> count == $past(wdata));

  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> cfg_en);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt[0] && !cnt_load && cmp_wr == '0) |=> !match_evt[0]);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_st
    assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[g] |=> status[g]);
  end

  assert_legacy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_leg && !match_evt[0]) |-> !pit_irq_out);
endmodule

bind et_event_timer et_event_timer_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cnt_load(cnt_load), .cmp_wr(cmp_wr),
  .wdata(wdata), .cfg_en(cfg.en), .cfg_leg(cfg.leg), .count(count),
  .match_evt(match_evt), .status(status), .irq_out(irq_out), .pit_irq_out(pit_irq_out)
);

// File: tb/test_et_event_timer.sv
`timescale 1ns/1ps
module test_et_event_timer;
  localparam int NT = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NT-1:0] irq_out;
  logic pit_irq_in = 0, rtc_irq_in = 0;
  logic pit_irq_out, rtc_irq_out;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  et_event_timer #(.NUM_TIMERS(NT)) i_et_event_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .pit_irq_in(pit_irq_in),
    .rtc_irq_in(rtc_irq_in), .pit_irq_out(pit_irq_out), .rtc_irq_out(rtc_irq_out)
  );

  localparam int NV = 10;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h20,
                                          8'hF0, 8'h40, 8'h48, 8'h50, 8'h80};
  localparam logic [31:0] V_EXP  [NV] = '{32'h8086A201, 32'h00989680, 32'h0, 32'h0, 32'h0,
                                          32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0};
  localparam logic [23:0] V_TAG  [NV] = '{"R1 ", "R2 ", "R3 ", "R4 ", "R9 ",
                                          "R5 ", "R7 ", "R7 ", "R7 ", "R4 "};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    wr_en = 0; be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    rd_en = 1; addr = a; be = b;
    #1 d = rdata;
    rd_en = 0; be = 4'hF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL all: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, seen_cnt, seen_cnt2;
    int hits, hits2, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state and fixed registers (R1 R2 R3 R4 R5 R7 R9)
    for (int i = 0; i < NV; i++) begin
      rd(V_ADDR[i], v);
      check($sformatf("%s reset read @%h", V_TAG[i], V_ADDR[i]), v, V_EXP[i]);
    end

    // R1: write to identification word is ignored
    wr(8'h00, 32'h12345678);
    rd(8'h00, v); check("R1 id after write", v, 32'h8086A201);

    // R11: narrow accesses ignored
    wr(8'h10, 32'h3, 4'h3);
    rd(8'h10, v); check("R11 narrow write", v, 32'h0);
    rd(8'h00, v, 4'h1); check("R11 narrow read", v, 32'h0);

    // R3: reserved bits do not block the write
    wr(8'h10, 32'hFFFF_FFF2);
    rd(8'h10, v); check("R3 cfg reserved set", v, 32'h2);
    wr(8'h10, 32'h0);

    // R6: preload then enable
    wr(8'hF0, 32'd1000);
    rd(8'hF0, v); check("R6 preload held while off", v, 32'd1000);
    wr(8'h10, 32'h1);
    rd(8'hF0, v); check("R6 resumes from preload", v, 32'd1001);

    // R5: counting and holding
    rd(8'hF0, a); repeat (4) @(negedge clk); rd(8'hF0, b);
    check("R5 advances one per clock", b - a, 32'd5);
    wr(8'h10, 32'h0);
    rd(8'hF0, a); repeat (6) @(negedge clk); rd(8'hF0, b);
    check("R5 holds while disabled", b, a);
    wr(8'h10, 32'h1);
    rd(8'hF0, v); check("R5 continues after re-enable", v, a + 32'd1);
    wr(8'h10, 32'h0);

    // R7 R8 R9: comparator match
    wr(8'hF0, 32'd100);
    wr(8'h40, 32'd110);
    rd(8'h40, v); check("R7 comparator write", v, 32'd110);
    wr(8'h20, 32'h7);
    wr(8'h10, 32'h1);
    hits = 0; bad = 0; seen_cnt = '0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk); rd_en = 1; addr = 8'hF0; #1;
      if (irq_out[0]) begin hits++; seen_cnt = rdata; end
      if (irq_out[2:1] != 2'b00) bad++;
    end
    rd_en = 0;
    check("R8 single pulse count", 32'(hits), 32'd1);
    check("R8 pulse at comparator value", seen_cnt, 32'd110);
    check("R8 other timers quiet", 32'(bad), 32'd0);
    rd(8'h20, v); check("R9 status latched", v, 32'h1);
    wr(8'h20, 32'h2);
    rd(8'h20, v); check("R9 write zero keeps bit", v, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, v); check("R9 write one clears", v, 32'h0);
    wr(8'h10, 32'h0);

    // R8: no pulse while disabled, counter parked on comparator
    wr(8'hF0, 32'd110);
    hits = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); #1; if (irq_out[0]) hits++;
    end
    check("R8 no pulse while disabled", 32'(hits), 32'd0);

    // R8 R7: wrap against reset comparator of timer 2
    wr(8'hF0, 32'hFFFF_FFFD);
    wr(8'h10, 32'h1);
    hits = 0; seen_cnt = '0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); rd_en = 1; addr = 8'hF0; #1;
      if (irq_out[2]) begin hits++; seen_cnt = rdata; end
    end
    rd_en = 0;
    check("R8 timer2 pulse at reset comparator", seen_cnt, 32'hFFFF_FFFF);
    rd(8'hF0, v); check("R8 counter wrapped", v, 32'd4);
    wr(8'h10, 32'h0);

    // R10: legacy routing
    pit_irq_in = 1; rtc_irq_in = 1;
    @(negedge clk); #1;
    check("R10 pit passes through", {31'd0, pit_irq_out}, 32'd1);
    check("R10 rtc passes through", {31'd0, rtc_irq_out}, 32'd1);
    wr(8'h10, 32'h2);
    #1;
    check("R10 pit blocked", {31'd0, pit_irq_out}, 32'd0);
    check("R10 rtc blocked", {31'd0, rtc_irq_out}, 32'd0);
    wr(8'hF0, 32'd200);
    wr(8'h40, 32'd205);
    wr(8'h48, 32'd207);
    wr(8'h10, 32'h3);
    hits = 0; hits2 = 0; bad = 0; seen_cnt = '0; seen_cnt2 = '0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk); rd_en = 1; addr = 8'hF0; #1;
      if (pit_irq_out) begin hits++; seen_cnt = rdata; end
      if (rtc_irq_out) begin hits2++; seen_cnt2 = rdata; end
      if (irq_out[1:0] != 2'b00) bad++;
    end
    rd_en = 0;
    check("R10 pit pulses once", 32'(hits), 32'd1);
    check("R10 pit driven by timer0", seen_cnt, 32'd205);
    check("R10 rtc pulses once", 32'(hits2), 32'd1);
    check("R10 rtc driven by timer1", seen_cnt2, 32'd207);
    check("R10 irq_out 0/1 quiet", 32'(bad), 32'd0);
    wr(8'h10, 32'h1);
    #1;
    check("R10 pit restored", {31'd0, pit_irq_out}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule